// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port

This block is a small general-purpose I/O port with four pins, attached to a simple synchronous peripheral bus. The bus has an address, write data, a write strobe, a read strobe and read data. Software sets each pin's direction through a direction register. It sets the output levels through a data register. Reading the data register returns a per-bit mix: the stored bit for each output pin, and the synchronized pin level for each input pin.

The direction register can be written but not read back; a read at its address returns all ones. The upper four bits of both byte-wide registers are not implemented and read as ones. A per-pin function-select input comes from an outside control register. A pin may drive only while its function-select bit marks it as general-purpose; otherwise this block holds that pin's output enable low. The stored data still drives the pin's output value, so nothing is lost when the pin is handed back.

Top module: `gpio4_port`

## Requirements
- R1: After reset, the stored data bits and direction bits are all 0, so `pin_oe` and `pin_out` are 0. A data-register read returns 0xF0 until the synchronizer has captured the pin levels.
- R2: A write strobe at address 0xFFDD updates the stored data bits from `bus_wdata[3:0]` on that clock edge, and `pin_out` follows on the same edge. Bits 7 to 4 of the write data have no effect.
- R3: A write strobe at address 0xFFED updates the direction bits from `bus_wdata[3:0]` on that edge. A direction bit of 1 makes that pin an output, and 0 makes it an input.
- R4: A read strobe at 0xFFDD returns bits 7..4 as 1. Each bit i in 3..0 returns the stored data bit when direction bit i is 1, and the synchronized pin level when it is 0.
- R5: The pin levels pass through two flops, so the read value of an input pin is the `pin_in` level sampled two rising clock edges earlier.
- R6: A read strobe at 0xFFED returns 0xFF, whatever direction value was written.
- R7: A read strobe at any other address returns 0x00. A write at any other address changes neither register.
- R8: `pin_oe[i]` is 1 only when direction bit i is 1 and `gp_sel[i]` is 1 (1 means general-purpose). With `gp_sel[i]` at 0 the enable is forced to 0.
- R9: Data bits written while a pin is an input are kept. They appear on `pin_out`, with the enable set, from the edge that makes the pin an output.
- R10: With the read strobe low, `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| gp_sel | input | 4 | Per-pin general-purpose select, 1 = GPIO |
| pin_in | input | 4 | Pin levels from the pads |
| pin_out | output | 4 | Output values to the pads |
| pin_oe | output | 4 | Output enables to the pads |

## Verification
The hardest case to reach from the ports is a single data-register read that returns mixed bits. In that read, output bits show stored values that differ from the pin levels, and input bits show levels that changed only two edges earlier. The stimulus changes `pin_in` on most cycles and writes both registers at random. It keeps random data written in both input and output positions, so a swapped mux select or a wrong synchronizer depth shows up. Directed steps add a data write followed by a later direction flip (R9), and a single pin pulse read one and two edges later (R5).

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;

    // Which register the current bus address selects.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] async_in,
    output logic [NP-1:0] sync_out
);

    typedef struct packed {
        logic [NP-1:0] stage1;
        logic [NP-1:0] stage2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_in;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.stage2;

endmodule

// File: rtl/gpio4_regs.sv
module gpio4_regs
    import gpio4_pkg::*;
#(
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [NP-1:0] wr_bits,
    output logic [NP-1:0] data_q,
    output logic [NP-1:0] dir_q
);

    typedef struct packed {
        logic [NP-1:0] data;
        logic [NP-1:0] dir;
    } reg_state_t;

    reg_state_t rs_d, rs_q;

    always_comb begin
        rs_d = rs_q;
        if (wr_en) begin
            unique case (sel)
                SEL_DATA: rs_d.data = wr_bits;
                SEL_DIR:  rs_d.dir  = wr_bits;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign data_q = rs_q.data;
    assign dir_q  = rs_q.dir;

    // R2: a data write lands on the next edge
    a_r2_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DATA) |=> data_q == $past(wr_bits));

    // R3: a direction write lands on the next edge
    a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DIR) |=> dir_q == $past(wr_bits));

    // R7: without a data write the data bits hold
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_DATA) |=> $stable(data_q));

    // R7: without a direction write the direction bits hold
    a_r7_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_DIR) |=> $stable(dir_q));

endmodule

// File: rtl/gpio4_rdmux.sv
module gpio4_rdmux
    import gpio4_pkg::*;
#(
    parameter int NP = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  reg_sel_e      sel,
    input  logic [NP-1:0] data_q,
    input  logic [NP-1:0] dir_q,
    input  logic [NP-1:0] pins_sync,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] port_view;

    // Per-bit choice between stored data and the synchronized pin level.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i < NP) begin : g_impl
            assign port_view[i] = dir_q[i] ? data_q[i] : pins_sync[i];
        end else begin : g_pad
            assign port_view[i] = 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_DATA: rdata = port_view;
                SEL_DIR:  rdata = '1;
                default:  rdata = '0;
            endcase
        end
    end

    // R6: the direction address reads as all ones
    a_r6_dir_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_DIR) |-> rdata == {DW{1'b1}});

    // R7: an unmapped address reads as zero
    a_r7_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |-> rdata == '0);

    // R10: the bus is quiet with no read strobe
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

endmodule

// File: rtl/gpio4_port.sv
module gpio4_port
    import gpio4_pkg::*;
#(
    parameter int          NP        = 4,
    parameter int          DW        = 8,
    parameter int          AW        = 16,
    parameter logic [AW-1:0] DATA_ADDR = 16'hFFDD,
    parameter logic [AW-1:0] DIR_ADDR  = 16'hFFED
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    input  logic          bus_re,
    output logic [DW-1:0] bus_rdata,
    input  logic [NP-1:0] gp_sel,
    input  logic [NP-1:0] pin_in,
    output logic [NP-1:0] pin_out,
    output logic [NP-1:0] pin_oe
);

    localparam int UPPER = DW - NP;

    reg_sel_e      sel;
    logic [NP-1:0] data_q;
    logic [NP-1:0] dir_q;
    logic [NP-1:0] pins_sync;
    logic          unused_upper;

    assign unused_upper = &{1'b0, bus_wdata[DW-1:NP]};

    always_comb begin
        if (bus_addr == DATA_ADDR) begin
            sel = SEL_DATA;
        end else if (bus_addr == DIR_ADDR) begin
            sel = SEL_DIR;
        end else begin
            sel = SEL_NONE;
        end
    end

    gpio4_sync #(.NP(NP)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    gpio4_regs #(.NP(NP)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .sel     (sel),
        .wr_bits (bus_wdata[NP-1:0]),
        .data_q  (data_q),
        .dir_q   (dir_q)
    );

    gpio4_rdmux #(.NP(NP), .DW(DW)) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_re),
        .sel       (sel),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .pins_sync (pins_sync),
        .rdata     (bus_rdata)
    );

    assign pin_out = data_q;
    assign pin_oe  = dir_q & gp_sel;

    // R8: no enable on a pin that is not general-purpose
    a_r8_oe_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~gp_sel) == '0);

    // R4: output bits read back what the pins drive
    a_r4_output_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && sel == SEL_DATA) |-> ((bus_rdata[NP-1:0] ^ pin_out) & dir_q) == '0);

    // R4: unimplemented bits read as ones
    a_r4_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && sel == SEL_DATA) |-> bus_rdata[DW-1:NP] == {UPPER{1'b1}});

endmodule

// File: tb/sim_gpio4_port.sv
module sim_gpio4_port;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_DATA = 16'hFFDD;
    localparam logic [15:0] A_DIR  = 16'hFFED;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic [3:0]  gp_sel = '0;
    logic [3:0]  pin_in = '0;
    logic [3:0]  pin_out;
    logic [3:0]  pin_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference state from the requirements.
    logic [3:0] m_data, m_dir, m_p1, m_p2;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio4_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .gp_sel(gp_sel), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_data <= '0; m_dir <= '0; m_p1 <= '0; m_p2 <= '0;
        end else begin
            m_p1 <= pin_in;        // R5: two-edge delay
            m_p2 <= m_p1;
            if (bus_we && bus_addr == A_DATA) m_data <= bus_wdata[3:0];
            if (bus_we && bus_addr == A_DIR)  m_dir  <= bus_wdata[3:0];
        end
    end

    function automatic logic [7:0] exp_rdata();
        if (!bus_re) return 8'h00;                        // R10
        if (bus_addr == A_DATA)                           // R4
            return {4'hF, (m_dir & m_data) | (~m_dir & m_p2)};
        if (bus_addr == A_DIR) return 8'hFF;              // R6
        return 8'h00;                                     // R7
    endfunction

    function automatic string rd_tag();
        if (!bus_re) return "R10";
        if (bus_addr == A_DATA) return "R4";
        if (bus_addr == A_DIR) return "R6";
        return "R7";
    endfunction

    task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Check all outputs against the model; called mid-cycle after inputs settle.
    task automatic check_all(string ctx);
        cmp({ctx, " ", rd_tag(), " rdata"}, bus_rdata, exp_rdata());
        cmp({ctx, " R2 pin_out"}, {4'h0, pin_out}, {4'h0, m_data});
        cmp({ctx, " R3 R8 pin_oe"}, {4'h0, pin_oe}, {4'h0, m_dir & gp_sel});
    endtask

    task automatic step(logic [15:0] a, logic [7:0] wd, logic we, logic re,
                        logic [3:0] sel, logic [3:0] pins, string ctx);
        @(negedge clk);
        bus_addr = a; bus_wdata = wd; bus_we = we; bus_re = re;
        gp_sel = sel; pin_in = pins;
        #1;
        check_all(ctx);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5EED_0042));
        pin_in = 4'hA;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset values
        bus_re = 1'b1; bus_addr = A_DATA; #1;
        cmp("R1 reset read", bus_rdata, 8'hF0);
        cmp("R1 reset pin_oe", {4'h0, pin_oe}, 8'h00);
        cmp("R1 reset pin_out", {4'h0, pin_out}, 8'h00);

        // R5: a pulse on pin 0 seen two edges later
        step(A_DATA, 8'h00, 1'b0, 1'b1, 4'hF, 4'h0, "R5 settle");
        step(A_DATA, 8'h00, 1'b0, 1'b1, 4'hF, 4'h0, "R5 settle");
        step(A_DATA, 8'h00, 1'b0, 1'b1, 4'hF, 4'h1, "R5 rise");
        step(A_DATA, 8'h00, 1'b0, 1'b1, 4'hF, 4'h0, "R5 one edge");
        cmp("R5 not yet", bus_rdata, 8'hF0);
        step(A_DATA, 8'h00, 1'b0, 1'b1, 4'hF, 4'h0, "R5 two edges");
        cmp("R5 pulse", bus_rdata, 8'hF1);

        // R9: data written while input, then switched to output
        step(A_DATA, 8'h05, 1'b1, 1'b0, 4'hF, 4'h0, "R9 write data");
        step(16'h1234, 8'hFF, 1'b1, 1'b0, 4'hF, 4'h0, "R7 stray write");
        step(A_DIR, 8'hF5, 1'b1, 1'b0, 4'hF, 4'h0, "R9 set dir");
        step(A_DIR, 8'h00, 1'b0, 1'b1, 4'hF, 4'h0, "R6 dir read");
        cmp("R9 pin_out", {4'h0, pin_out}, 8'h05);
        cmp("R9 pin_oe", {4'h0, pin_oe}, 8'h05);
        step(A_DATA, 8'h00, 1'b0, 1'b1, 4'h4, 4'hA, "R8 gated");
        cmp("R8 oe gated", {4'h0, pin_oe}, 8'h04);
        // R2: upper write bits ignored
        step(A_DATA, 8'hA3, 1'b1, 1'b0, 4'hF, 4'hA, "R2 upper");
        step(A_DATA, 8'h00, 1'b0, 1'b1, 4'hF, 4'hA, "R2 readback");
        step(16'hFFDC, 8'h00, 1'b0, 1'b1, 4'hF, 4'hA, "R7 neighbour");
        cmp("R7 neighbour read", bus_rdata, 8'h00);

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] a;
            int r = $urandom_range(0, 9);
            if (r < 4) a = A_DATA;
            else if (r < 7) a = A_DIR;
            else a = 16'($urandom);
            step(a, 8'($urandom), 1'($urandom_range(0, 2) == 0),
                 1'($urandom_range(0, 3) != 0), 4'($urandom), 4'($urandom), "rand");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule